// File: doc/BRIEF.md
# Fifteen-Cent Coin Vending Controller

This block is the control state machine of a single-item vending point that charges 15 cents. It takes 5-cent and 10-cent coins on two separate pulse inputs, keeps a running credit of 0, 5, 10 or 15 cents, and answers two customer requests: a purchase request and a cash-back request. Every input is a one-cycle pulse sampled on the rising clock edge, and every output is a one-cycle pulse driven straight from a flip-flop. The result is a glitch-free item release and three change chutes (5, 10 and 15 cents).

Each clock cycle acts on one input only. When several inputs arrive together, a fixed priority picks the winner and the rest are dropped for that cycle. A coin that would push the credit past the price is paid straight back on the matching chute, so credit never goes above 15 cents and money is never lost. The credit register can be built as a two-bit binary code or as a four-bit one-hot code, set by a parameter.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the credit to 0 and drives all four outputs low in the following cycle.
- R2: Below 15 cents, a 5-cent coin adds 5 to the credit. A 10-cent coin adds 10 from 0 or 5 cents. Neither produces an output.
- R3: A 10-cent coin at 10 cents of credit sets the credit to 15 and pulses `chg_5`.
- R4: A purchase request at 15 cents pulses `item_drop` and clears the credit to 0. At any lower credit the request is ignored: no output, and the credit is unchanged.
- R5: At 15 cents of credit, a 5-cent coin pulses `chg_5` and a 10-cent coin pulses `chg_10`. The credit stays at 15.
- R6: A cash-back request pulses the chute that matches the credit (`chg_5` at 5, `chg_10` at 10, `chg_15` at 15) and clears the credit to 0. At 0 credit it produces no output.
- R7: When several inputs are high in one cycle, only one acts. The order is cash-back first, then purchase, then the 10-cent coin, then the 5-cent coin. The inputs that lose have no effect on the credit or the outputs.
- R8: Outputs come from registers. The response to an input sampled at edge N is visible after edge N+1's predecessor settles, which means it appears from edge N to edge N+1, and it lasts exactly one cycle.
- R9: At most one output is high in any cycle. Over a run that ends in a cash-back, the sum of the change paid plus 15 cents for each item dropped equals the sum of the coins accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_5 | input | 1 | 5-cent coin pulse |
| coin_10 | input | 1 | 10-cent coin pulse |
| buy_req | input | 1 | Purchase request pulse |
| cash_back | input | 1 | Cash-back request pulse |
| item_drop | output | 1 | Release one item |
| chg_5 | output | 1 | Pay out 5 cents |
| chg_10 | output | 1 | Pay out 10 cents |
| chg_15 | output | 1 | Pay out 15 cents |

## Verification
The bench targets the situations a careless controller gets wrong:
- A 10-cent coin at 10 cents. A wrong design wraps the credit or swallows the surplus 5 cents.
- A coin at full credit. A wrong design keeps it or clears the credit.
- A purchase at partial credit. A wrong design drops an item or zeroes the credit.
- Cash-back at zero credit. A wrong design pays out spurious change.

Random combinations of simultaneous inputs test the priority order, because a flipped priority shows up as the wrong chute or a missing release. A closing cash-back balances the money inserted against the money paid out, which exposes any silent loss or duplication of credit.

// File: rtl/vend_pkg.sv
package vend_pkg;

   typedef enum logic [1:0] {
      CR_0  = 2'd0,
      CR_5  = 2'd1,
      CR_10 = 2'd2,
      CR_15 = 2'd3
   } credit_e;

   localparam int unsigned CREDIT_STATES = 4;

   typedef enum logic [2:0] {
      OP_IDLE   = 3'd0,
      OP_NICKEL = 3'd1,
      OP_DIME   = 3'd2,
      OP_BUY    = 3'd3,
      OP_CASH   = 3'd4
   } op_e;

   typedef struct packed {
      logic drop;
      logic c5;
      logic c10;
      logic c15;
   } pay_s;

endpackage

// File: rtl/vend_arbiter.sv
module vend_arbiter
   import vend_pkg::*;
(
   input  logic coin_5,
   input  logic coin_10,
   input  logic buy_req,
   input  logic cash_back,
   output op_e  op
);
   always_comb begin
      if (cash_back)    op = OP_CASH;
      else if (buy_req) op = OP_BUY;
      else if (coin_10) op = OP_DIME;
      else if (coin_5)  op = OP_NICKEL;
      else              op = OP_IDLE;
   end
endmodule

// File: rtl/vend_step.sv
module vend_step
   import vend_pkg::*;
(
   input  credit_e cur,
   input  op_e     op,
   output credit_e nxt,
   output pay_s    pay
);
   always_comb begin
      nxt = cur;
      pay = '0;
      unique case (op)
         OP_CASH: begin
            nxt = CR_0;
            unique case (cur)
               CR_5:    pay.c5  = 1'b1;
               CR_10:   pay.c10 = 1'b1;
               CR_15:   pay.c15 = 1'b1;
               default: ;
            endcase
         end
         OP_BUY: begin
            if (cur == CR_15) begin
               nxt      = CR_0;
               pay.drop = 1'b1;
            end
         end
         OP_DIME: begin
            unique case (cur)
               CR_0:    nxt = CR_10;
               CR_5:    nxt = CR_15;
               CR_10: begin
                  nxt    = CR_15;
                  pay.c5 = 1'b1;
               end
               default: pay.c10 = 1'b1;
            endcase
         end
         OP_NICKEL: begin
            unique case (cur)
               CR_0:    nxt = CR_5;
               CR_5:    nxt = CR_10;
               CR_10:   nxt = CR_15;
               default: pay.c5 = 1'b1;
            endcase
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
   import vend_pkg::*;
#(
   parameter int unsigned STATE_ENC = 0
)(
   input  logic    clk,
   input  logic    rst,
   input  credit_e nxt,
   output credit_e cur
);
   generate
      if (STATE_ENC == 0) begin : g_binary
         credit_e bin_q;
         always_ff @(posedge clk) begin
            if (rst) bin_q <= CR_0;
            else     bin_q <= nxt;
         end
         assign cur = bin_q;
      end else if (STATE_ENC == 1) begin : g_onehot
         logic [CREDIT_STATES-1:0] oh_q;
         always_ff @(posedge clk) begin
            if (rst) oh_q <= CREDIT_STATES'(1);
            else     oh_q <= CREDIT_STATES'(1) << nxt;
         end
         always_comb begin
            if (oh_q[3])      cur = CR_15;
            else if (oh_q[2]) cur = CR_10;
            else if (oh_q[1]) cur = CR_5;
            else              cur = CR_0;
         end
      end else begin : g_bad_enc
         $error("vend_state_reg: STATE_ENC must be 0 or 1");
      end
   endgenerate
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
   import vend_pkg::*;
#(
   parameter int unsigned STATE_ENC = 0
)(
   input  logic clk,
   input  logic rst,
   input  logic coin_5,
   input  logic coin_10,
   input  logic buy_req,
   input  logic cash_back,
   output logic item_drop,
   output logic chg_5,
   output logic chg_10,
   output logic chg_15
);
   op_e     op;
   credit_e credit_q;
   credit_e credit_d;
   pay_s    pay_d;
   pay_s    pay_q;

   vend_arbiter u_arb (
      .coin_5    (coin_5),
      .coin_10   (coin_10),
      .buy_req   (buy_req),
      .cash_back (cash_back),
      .op        (op)
   );

   vend_step u_step (
      .cur (credit_q),
      .op  (op),
      .nxt (credit_d),
      .pay (pay_d)
   );

   vend_state_reg #(.STATE_ENC(STATE_ENC)) u_state (
      .clk (clk),
      .rst (rst),
      .nxt (credit_d),
      .cur (credit_q)
   );

   always_ff @(posedge clk) begin
      if (rst) pay_q <= '0;
      else     pay_q <= pay_d;
   end

   assign item_drop = pay_q.drop;
   assign chg_5     = pay_q.c5;
   assign chg_10    = pay_q.c10;
   assign chg_15    = pay_q.c15;
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
   import vend_pkg::*;
(
   input logic    clk,
   input logic    rst,
   input logic    coin_5,
   input logic    coin_10,
   input logic    buy_req,
   input logic    cash_back,
   input logic    item_drop,
   input logic    chg_5,
   input logic    chg_10,
   input logic    chg_15,
   input credit_e credit_q
);
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (credit_q == CR_0) && !item_drop && !chg_5 && !chg_10 && !chg_15);

   a_r9_single_output: assert property (@(posedge clk) disable iff (rst)
      $countones({item_drop, chg_5, chg_10, chg_15}) <= 1);

   a_r4_drop_needs_buy: assert property (@(posedge clk) disable iff (rst)
      item_drop |-> $past(buy_req) && !$past(cash_back));

   a_r6_cash_back_clears: assert property (@(posedge clk) disable iff (rst)
      cash_back |=> credit_q == CR_0);

   a_r5_full_credit_holds: assert property (@(posedge clk) disable iff (rst)
      (credit_q == CR_15) && !buy_req && !cash_back |=> credit_q == CR_15);

   a_r8_chg15_from_cash: assert property (@(posedge clk) disable iff (rst)
      chg_15 |-> $past(cash_back));
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .coin_5    (coin_5),
   .coin_10   (coin_10),
   .buy_req   (buy_req),
   .cash_back (cash_back),
   .item_drop (item_drop),
   .chg_5     (chg_5),
   .chg_10    (chg_10),
   .chg_15    (chg_15),
   .credit_q  (credit_q)
);

// File: tb/tb_vend_ctrl.sv
`timescale 1ns/1ps
module tb_vend_ctrl;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic coin_5 = 1'b0, coin_10 = 1'b0, buy_req = 1'b0, cash_back = 1'b0;
   logic item_drop, chg_5, chg_10, chg_15;

   int checks = 0;
   int fails  = 0;
   int model_cr = 0;
   int inserted = 0;
   int paid = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vend_ctrl dut (
      .clk(clk), .rst(rst), .coin_5(coin_5), .coin_10(coin_10),
      .buy_req(buy_req), .cash_back(cash_back),
      .item_drop(item_drop), .chg_5(chg_5), .chg_10(chg_10), .chg_15(chg_15)
   );

   // Expected outputs {drop,c5,c10,c15}; updates model credit and accepted total.
   function automatic logic [3:0] predict(input bit n, input bit d, input bit b,
                                          input bit r, output string tag);
      logic [3:0] o = 4'b0000;
      bool_multi(n, d, b, r, tag);
      if (r) begin
         case (model_cr)
            5:  o = 4'b0100;
            10: o = 4'b0010;
            15: o = 4'b0001;
            default: o = 4'b0000;
         endcase
         if (tag == "") tag = "R6";
         model_cr = 0;
      end else if (b) begin
         if (tag == "") tag = "R4";
         if (model_cr == 15) begin o = 4'b1000; model_cr = 0; end
      end else if (d) begin
         inserted += 10;
         if (model_cr == 15)      begin o = 4'b0010; if (tag == "") tag = "R5"; end
         else if (model_cr == 10) begin o = 4'b0100; model_cr = 15; if (tag == "") tag = "R3"; end
         else begin model_cr += 10; if (tag == "") tag = "R2"; end
      end else if (n) begin
         inserted += 5;
         if (model_cr == 15) begin o = 4'b0100; if (tag == "") tag = "R5"; end
         else begin model_cr += 5; if (tag == "") tag = "R2"; end
      end else begin
         if (tag == "") tag = "R8";
      end
      return o;
   endfunction

   function automatic void bool_multi(input bit n, input bit d, input bit b,
                                      input bit r, output string tag);
      tag = (int'(n) + int'(d) + int'(b) + int'(r) > 1) ? "R7" : "";
   endfunction

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: outputs {drop,c5,c10,c15} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // Drive one cycle of inputs, then check the registered response after the edge.
   task automatic step(input bit n, input bit d, input bit b, input bit r);
      string tag;
      logic [3:0] exp;
      coin_5 = n; coin_10 = d; buy_req = b; cash_back = r;
      exp = predict(n, d, b, r, tag);
      @(posedge clk); #1;
      coin_5 = 0; coin_10 = 0; buy_req = 0; cash_back = 0;
      paid += 5 * int'(chg_5) + 10 * int'(chg_10) + 15 * int'(chg_15) + 15 * int'(item_drop);
      check(tag, {item_drop, chg_5, chg_10, chg_15}, exp);
      if ($countones({item_drop, chg_5, chg_10, chg_15}) > 1)
         check("R9", 4'b1111, 4'b0000);
   endtask

   initial begin
      void'($urandom(32'd1234));
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R1", {item_drop, chg_5, chg_10, chg_15}, 4'b0000);
      rst = 1'b0;

      // R6: cash-back at zero credit pays nothing
      step(0, 0, 0, 1);
      // R2 then R4: purchase at 10 is ignored, credit kept (R6 returns 10)
      step(1, 0, 0, 0); step(1, 0, 0, 0);
      step(0, 0, 1, 0);
      step(0, 0, 0, 1);
      // R3: dime at 10 gives 15 and change of 5
      step(0, 1, 0, 0); step(0, 1, 0, 0);
      // R5: coins at full credit bounce back
      step(1, 0, 0, 0); step(0, 1, 0, 0);
      // R4: purchase at 15
      step(0, 0, 1, 0);
      // R6: refund 15 and 5
      step(0, 1, 0, 0); step(1, 0, 0, 0); step(0, 0, 0, 1);
      step(1, 0, 0, 0); step(0, 0, 0, 1);
      // R7: priority combinations
      step(0, 1, 0, 0); step(1, 1, 1, 0);
      step(1, 1, 0, 1);
      step(1, 1, 0, 0); step(1, 1, 1, 1);
      step(0, 0, 0, 1);

      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 4) == 0, ($urandom % 4) == 0,
              ($urandom % 5) == 0, ($urandom % 9) == 0);
      end

      // R9: close with a cash-back and balance the books
      step(0, 0, 0, 1);
      checks++;
      if (paid != inserted) begin
         fails++;
         $display("FAIL R9: money out actual=%0d expected=%0d", paid, inserted);
      end

      // R1: reset mid-credit clears it (a later cash-back pays nothing)
      step(1, 0, 0, 0);
      rst = 1'b1; @(posedge clk); #1; rst = 1'b0;
      model_cr = 0;
      check("R1", {item_drop, chg_5, chg_10, chg_15}, 4'b0000);
      step(0, 0, 0, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule